// File: doc/BRIEF.md
# Interrupt-Entry Completion-Queue Controller

This block decides when a pending external interrupt is taken relative to a four-entry in-order completion queue. The request line is level-sensitive and is honoured only while the external-enable bit of the machine state register is set. When the request is recognised, the block takes a snapshot of the queue. It then walks the snapshot from oldest to youngest, one entry per cycle. Each entry is either retired or discarded together with its results. The interrupt is bound to the youngest entry, which may retire only if it belongs to a restricted set of instruction classes.

After the walk, the block enters the handler in one cycle. It saves the restart address and the old machine state, builds the new machine state, and redirects fetch to the external interrupt vector. A separate return-from-interrupt strobe restores both saved registers. Because the request is not latched, an interrupt that is still asserted is taken again once the restored state re-enables it. A move-to-MSR port lets software set the state register directly.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A request is recognised only in an idle cycle where `irq_req`=1, `msr` bit 15 (external enable) = 1, and neither `msr_wr` nor `rfi` is high. Otherwise the request has no effect and `busy` stays 0.
- R2: From the cycle after recognition, `busy` is 1. Snapshot entries are handled in index order (index 0 is oldest, the youngest is the highest valid index), one per cycle. A non-youngest entry retires (`retire_vld` pulse with its PC) when it is completed and not faulted.
- R3: The youngest entry retires only if it is completed, not faulted, and its class is 0 (move-to-SPR), 1 (move-to-MSR), 2 (return-from-interrupt), 3 (memory reference) or 4 (memory/cache control). Classes 5–7 are discarded.
- R4: Once any entry is discarded (`discard_vld` pulse with its PC), every later entry in the snapshot is discarded too. The restart address is the PC of the first discarded entry.
- R5: If every entry retires, the restart address is the last retired PC + 4. With an empty queue it is `fetch_pc`.
- R6: One cycle after the last entry is handled, `redirect_vld` pulses with `redirect_pc` = 0xFFF00500 if `msr` bit 6 (vector-high) is 1, and 0x00000500 otherwise. At the same time `srr0` receives the restart address and `srr1` the old `msr`.
- R7: On entry, the new `msr` has bit 15 cleared and bit 0 (little-endian) copied from bit 16 (interrupt little-endian). Bit 6 and all other bits are unchanged.
- R8: An idle-cycle `rfi` loads `msr` from `srr1` and, on the next cycle, pulses `redirect_vld` with `redirect_pc` = `srr0`. An idle-cycle `msr_wr` writes `msr_wdata`. If both arrive together, `msr_wr` wins.
- R9: The request is not latched. A request still high after a return that restores bit 15 = 1 is taken again.
- R10: After reset, `msr` = `MSR_RST` (0 by default), `srr0` = `srr1` = 0, `busy` = 0, and no pulse output is high.
- R11: At most one of `retire_vld`, `discard_vld` and `redirect_vld` is high in a cycle. `msr_wr` and `rfi` are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Level-sensitive external interrupt request |
| fetch_pc | input | 32 | Next fetch address, used as restart when queue is empty |
| q_valid | input | 4 | Per-entry valid, contiguous from index 0 |
| q_done | input | 4 | Per-entry completed flag |
| q_fault | input | 4 | Per-entry exception flag |
| q_class | input | 12 | Per-entry 3-bit class, entry i at [3i+2:3i] |
| q_pc | input | 128 | Per-entry PC, entry i at [32i+31:32i] |
| msr_wr | input | 1 | Move-to-MSR strobe |
| msr_wdata | input | 32 | Move-to-MSR data |
| rfi | input | 1 | Return-from-interrupt strobe |
| busy | output | 1 | Snapshot being handled or entry in progress |
| retire_vld | output | 1 | An entry retired this cycle |
| retire_pc | output | 32 | PC of the retired entry |
| discard_vld | output | 1 | An entry was discarded this cycle |
| discard_pc | output | 32 | PC of the discarded entry |
| redirect_vld | output | 1 | Fetch redirect |
| redirect_pc | output | 32 | Redirect target |
| msr | output | 32 | Machine state register |
| srr0 | output | 32 | Saved restart address |
| srr1 | output | 32 | Saved machine state |

## Verification
The assertions assume that valid queue entries are contiguous from index 0. They also assume that the strobes `rfi` and `msr_wr` come only from an idle core. Neither is checked, because the block depends on the first assumption and simply ignores strobes that break the second. The stimulus always builds queues as a prefix of valid entries, and raises `msr_wr` during a drain only to show that it is ignored. Expected retire, discard and redirect events are derived from the classes and flags the stimulus chose. Those events are then matched in order against the pulses the block produces.

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int          DEPTH   = 4,
  parameter int          CW      = 3,
  parameter logic [31:0] MSR_RST = 32'h0,
  parameter logic [31:0] VEC_HI  = 32'hFFF0_0000,
  parameter logic [11:0] EXT_OFS = 12'h500,
  parameter int          QUAL_MAX = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 irq_req,
  input  logic [31:0]          fetch_pc,
  input  logic [DEPTH-1:0]     q_valid,
  input  logic [DEPTH-1:0]     q_done,
  input  logic [DEPTH-1:0]     q_fault,
  input  logic [CW*DEPTH-1:0]  q_class,
  input  logic [32*DEPTH-1:0]  q_pc,
  input  logic                 msr_wr,
  input  logic [31:0]          msr_wdata,
  input  logic                 rfi,
  output logic                 busy,
  output logic                 retire_vld,
  output logic [31:0]          retire_pc,
  output logic                 discard_vld,
  output logic [31:0]          discard_pc,
  output logic                 redirect_vld,
  output logic [31:0]          redirect_pc,
  output logic [31:0]          msr,
  output logic [31:0]          srr0,
  output logic [31:0]          srr1
);
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int B_LE  = 0;
  localparam int B_IP  = 6;
  localparam int B_EE  = 15;
  localparam int B_ILE = 16;

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_ENTER} st_t;
  st_t st;

  logic [31:0]   s_pc  [DEPTH];
  logic [CW-1:0] s_cls [DEPTH];
  logic [DEPTH-1:0] s_done, s_fault;
  logic [IW-1:0] idx, last;
  logic          dropping;
  logic [31:0]   restart;

  logic [IW-1:0] last_c;
  logic          any_c;
  always_comb begin
    last_c = '0;
    any_c  = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (q_valid[i]) begin
        last_c = IW'(i);
        any_c  = 1'b1;
      end
  end

  logic        cur_ok;
  logic [31:0] cur_pc;
  assign cur_pc = s_pc[idx];
  assign cur_ok = !dropping && s_done[idx] && !s_fault[idx] &&
                  ((idx != last) || (int'(s_cls[idx]) <= QUAL_MAX));

  logic [31:0] entry_msr;
  always_comb begin
    entry_msr       = msr;
    entry_msr[B_EE] = 1'b0;
    entry_msr[B_LE] = msr[B_ILE];
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      msr          <= MSR_RST;
      srr0         <= '0;
      srr1         <= '0;
      idx          <= '0;
      last         <= '0;
      dropping     <= 1'b0;
      restart      <= '0;
      retire_vld   <= 1'b0;
      retire_pc    <= '0;
      discard_vld  <= 1'b0;
      discard_pc   <= '0;
      redirect_vld <= 1'b0;
      redirect_pc  <= '0;
      s_done       <= '0;
      s_fault      <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        s_pc[i]  <= '0;
        s_cls[i] <= '0;
      end
    end else begin
      retire_vld   <= 1'b0;
      discard_vld  <= 1'b0;
      redirect_vld <= 1'b0;
      case (st)
        S_IDLE: begin
          if (msr_wr) begin
            msr <= msr_wdata;
          end else if (rfi) begin
            msr          <= srr1;
            redirect_vld <= 1'b1;
            redirect_pc  <= srr0;
          end else if (irq_req && msr[B_EE]) begin
            for (int i = 0; i < DEPTH; i++) begin
              s_pc[i]  <= q_pc[32*i +: 32];
              s_cls[i] <= q_class[CW*i +: CW];
            end
            s_done   <= q_done;
            s_fault  <= q_fault;
            idx      <= '0;
            last     <= last_c;
            dropping <= 1'b0;
            restart  <= fetch_pc;
            st       <= any_c ? S_DRAIN : S_ENTER;
          end
        end
        S_DRAIN: begin
          if (cur_ok) begin
            retire_vld <= 1'b1;
            retire_pc  <= cur_pc;
            restart    <= cur_pc + 32'd4;
          end else begin
            discard_vld <= 1'b1;
            discard_pc  <= cur_pc;
            dropping    <= 1'b1;
            if (!dropping) restart <= cur_pc;
          end
          if (idx == last) st <= S_ENTER;
          else idx <= idx + 1'b1;
        end
        S_ENTER: begin
          srr0         <= restart;
          srr1         <= msr;
          msr          <= entry_msr;
          redirect_vld <= 1'b1;
          redirect_pc  <= msr[B_IP] ? (VEC_HI | {20'h0, EXT_OFS}) : {20'h0, EXT_OFS};
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_no_ee_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !msr[B_EE]) |=> !busy);
  // R2
  retire_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_vld |-> busy);
  // R4
  no_retire_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discard_vld |=> !retire_vld);
  // R6
  entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENTER) |=> (redirect_vld && srr1 == $past(msr) && srr0 == $past(restart)));
  // R7
  entry_msr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENTER) |=> (!msr[B_EE] && msr[B_LE] == $past(msr[B_ILE]) && msr[B_IP] == $past(msr[B_IP])));
  // R8
  rfi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rfi && !msr_wr) |=> (msr == $past(srr1) && redirect_pc == $past(srr0)));
  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retire_vld, discard_vld, redirect_vld}));
  // R11
  busy_hold_msr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN) |=> $stable(msr));
endmodule

// File: tb/sim_irq_entry_ctrl.sv
module sim_irq_entry_ctrl;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic irq_req = 0, msr_wr = 0, rfi = 0;
  logic [31:0] fetch_pc = 0, msr_wdata = 0;
  logic [3:0] q_valid = 0, q_done = 0, q_fault = 0;
  logic [11:0] q_class = 0;
  logic [127:0] q_pc = 0;
  logic busy, retire_vld, discard_vld, redirect_vld;
  logic [31:0] retire_pc, discard_pc, redirect_pc, msr, srr0, srr1;

  irq_entry_ctrl u0 (.*);

  int checks = 0, failures = 0;
  logic [33:0] sb[$];
  logic [31:0] m_msr = 0, m_srr0 = 0, m_srr1 = 0;
  string cur_req = "R2";
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n) begin
    logic [1:0] k; logic [31:0] p; logic [33:0] e;
    k = 2'd3; p = 0;
    if (retire_vld)   begin k = 0; p = retire_pc;   end
    if (discard_vld)  begin k = 1; p = discard_pc;  end
    if (redirect_vld) begin k = 2; p = redirect_pc; end
    if (retire_vld + discard_vld + redirect_vld > 1) chk("R11", 1, 0);
    if (k != 3) begin
      if (sb.size() == 0) chk(cur_req, {30'h0, k}, 32'hDEAD);
      else begin
        e = sb.pop_front();
        chk({cur_req, " kind"}, {30'h0, k}, {30'h0, e[33:32]});
        chk({cur_req, " pc"}, p, e[31:0]);
      end
    end
  end

  function automatic logic [31:0] enter_msr(logic [31:0] m);
    logic [31:0] r = m;
    r[15] = 0; r[0] = m[16];
    return r;
  endfunction

  task automatic load_q(int n, logic [3:0] d, logic [3:0] f, logic [11:0] c, logic [31:0] base);
    q_valid = 4'((1 << n) - 1); q_done = d; q_fault = f; q_class = c;
    for (int i = 0; i < 4; i++) q_pc[32*i +: 32] = base + 32'(4*i);
  endtask

  // push expected events for the current queue and update the model
  task automatic expect_entry();
    int last = -1; bit drop = 0; logic [31:0] rs = fetch_pc;
    for (int i = 0; i < 4; i++) if (q_valid[i]) last = i;
    for (int i = 0; i <= last; i++) begin
      logic [31:0] pc = q_pc[32*i +: 32];
      bit ok = !drop && q_done[i] && !q_fault[i] && (i != last || q_class[3*i +: 3] <= 3'd4);
      if (ok) begin sb.push_back({2'd0, pc}); rs = pc + 4; end
      else begin sb.push_back({2'd1, pc}); if (!drop) rs = pc; drop = 1; end
    end
    sb.push_back({2'd2, m_msr[6] ? 32'hFFF00500 : 32'h00000500});
    m_srr0 = rs; m_srr1 = m_msr; m_msr = enter_msr(m_msr);
  endtask

  task automatic take_irq(string req);
    cur_req = req;
    expect_entry();
    @(negedge clk) irq_req = 1;
    @(negedge clk) irq_req = 0;
    repeat (7) @(negedge clk);
    chk({req, " busy"}, {31'h0, busy}, 0);
    chk("R6 srr0", srr0, m_srr0);
    chk("R6 srr1", srr1, m_srr1);
    chk("R7 msr", msr, m_msr);
    chk({req, " sb empty"}, sb.size(), 0);
  endtask

  task automatic write_msr(logic [31:0] v);
    @(negedge clk) begin msr_wr = 1; msr_wdata = v; end
    @(negedge clk) msr_wr = 0;
    m_msr = v;
  endtask

  task automatic do_rfi();
    cur_req = "R8";
    sb.push_back({2'd2, m_srr0});
    @(negedge clk) rfi = 1;
    @(negedge clk) rfi = 0;
    m_msr = m_srr1;
    repeat (2) @(negedge clk);
    chk("R8 msr", msr, m_msr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10
    chk("R10 msr", msr, 0); chk("R10 srr0", srr0, 0); chk("R10 srr1", srr1, 0);
    chk("R10 pulses", {28'h0, busy, retire_vld, discard_vld, redirect_vld}, 0);

    // R1: no EE, request ignored
    load_q(2, 4'hF, 0, 12'h333, 32'h100);
    irq_req = 1;
    repeat (5) @(negedge clk);
    chk("R1 busy", {31'h0, busy}, 0);
    irq_req = 0;
    chk("R1 srr0", srr0, 0);

    // R2 R3 R7: all retire, tail memory ref, ILE=1
    write_msr(32'h0001_8000);
    load_q(3, 4'hF, 0, {3'd0, 3'd3, 3'd5, 3'd5}, 32'h1000);
    take_irq("R2");
    chk("R5 restart", srr0, 32'h1000 + 8 + 4);
    do_rfi();

    // R3: tail class 5 discarded; R11 msr_wr during drain ignored
    load_q(3, 4'hF, 0, {3'd0, 3'd5, 3'd0, 3'd0}, 32'h2000);
    cur_req = "R3";
    expect_entry();
    @(negedge clk) irq_req = 1;
    @(negedge clk) begin irq_req = 0; msr_wr = 1; msr_wdata = 32'hFFFF_FFFF; end
    @(negedge clk) msr_wr = 0;
    repeat (6) @(negedge clk);
    chk("R11 msr", msr, m_msr);
    chk("R4 srr0", srr0, 32'h2008);
    do_rfi();

    // R3: each qualifying class retires at the tail
    for (int c = 0; c < 8; c++) begin
      load_q(1, 4'hF, 0, 12'(c), 32'h3000 + 32'(c * 16));
      take_irq("R3");
      do_rfi();
    end

    // R3: faulted tail discarded
    load_q(2, 4'hF, 4'b0010, {6'd0, 3'd3, 3'd3}, 32'h4000);
    take_irq("R3");
    chk("R3 srr0", srr0, 32'h4004);
    do_rfi();

    // R4: older entry incomplete, everything after dropped
    load_q(4, 4'b1101, 0, 12'h0, 32'h5000);
    take_irq("R4");
    chk("R4 first drop", srr0, 32'h5004);
    do_rfi();

    // R5: empty queue
    load_q(0, 0, 0, 0, 0);
    fetch_pc = 32'h6660;
    take_irq("R5");
    chk("R5 fetch", srr0, 32'h6660);
    do_rfi();

    // R6: vector high
    write_msr(32'h0000_8040);
    load_q(1, 4'hF, 0, 12'h4, 32'h7000);
    take_irq("R6");
    do_rfi();

    // R8: msr_wr beats rfi
    @(negedge clk) begin msr_wr = 1; rfi = 1; msr_wdata = 32'h0000_0000; end
    @(negedge clk) begin msr_wr = 0; rfi = 0; end
    @(negedge clk);
    chk("R8 priority", msr, 0);
    chk("R8 no redirect", sb.size(), 0);
    m_msr = 0;

    // R9: request held through return, taken again
    write_msr(32'h0000_8000);
    load_q(0, 0, 0, 0, 0);
    fetch_pc = 32'h8800;
    take_irq("R9");
    cur_req = "R9";
    sb.push_back({2'd2, m_srr0});
    m_msr = m_srr1;
    expect_entry();
    @(negedge clk) begin rfi = 1; irq_req = 1; end
    @(negedge clk) rfi = 0;
    @(negedge clk) irq_req = 0;
    repeat (4) @(negedge clk);
    chk("R9 msr", msr, m_msr);
    chk("R9 srr1", srr1, 32'h0000_8000);
    chk("R9 sb empty", sb.size(), 0);

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule